// File: doc/BRIEF.md
# Floating-Point Control and Status Register Pair

This block keeps the two software-visible configuration registers of a small floating-point unit. The control register chooses how the arithmetic datapath rounds, and its two low bits drive the rounding-mode output continuously. The status register is a sticky collection of exception flags. Every operation that the datapath reports as finished ORs its flags into it, and software reads it or overwrites it.

Software reaches both registers through one 32-bit port: a write strobe, a register select and a data word, plus a separate read select. Writes are stored with a mask. Any write whose upper twenty bits are not all zero raises a one-cycle error pulse. The write is still stored in masked form. A parameter picks a legacy control-register variant that keeps the upper bits of a written word and clears only the flag-field positions.

Top module: `fpu_csr_bank`

## Requirements
- R1: A synchronous active-high reset clears both registers, drives round_mode to 0 (round to nearest even) and clears rsvd_err.
- R2: round_mode equals control bits [1:0] from the cycle after a control write. The encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: With LEGACY=0, a control write (wr_sel=0) stores wr_data & 0x0000007F. A control read (rd_sel=0) returns the stored word.
- R4: With LEGACY=1, a control write stores wr_data & 0xFFFFF07F, which clears only bits [11:7].
- R5: Any write with wr_en=1 whose wr_data[31:12] is non-zero drives rsvd_err high for exactly the following cycle, for either register. The masked value is still stored. No pulse follows a write with clean upper bits, and none follows when wr_en=0.
- R6: A status write (wr_sel=1) keeps only wr_data[11:7] as the 5-bit flag field. A status read (rd_sel=1) returns flags << 7 with every other bit zero.
- R7: In each cycle with op_valid=1 and no status write, op_flags is ORed into the flag field. Flag bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. With op_valid=0, op_flags has no effect.
- R8: When a status write and op_valid happen in the same cycle, the field takes the written value and the same-cycle op_flags are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Software write word |
| rd_sel | input | 1 | Read source: 0 control, 1 status |
| rd_data | output | 32 | Read word of the selected register |
| op_valid | input | 1 | Datapath operation completed this cycle |
| op_flags | input | 5 | Exception flags of the completed operation |
| round_mode | output | 2 | Rounding mode sent to the datapath |
| rsvd_err | output | 1 | One-cycle pulse after a write with reserved bits set |

## Verification
The checker runs on every cycle. It checks the masked storage of each control write for the chosen variant and that the rounding output follows such a write. It checks the one-cycle timing of the reserved-bit pulse, that the sticky field never loses a bit, and that a status write beats a simultaneous operation. The bench's scenarios cover the rest. A legacy instance driven in parallel shows that the two variants differ for the same word. Directed words with every bit set show which fields the read-back drops. Sequences of single-flag operations show accumulation in the documented bit order.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST_EVEN = 2'd0,
      RND_TO_ZERO      = 2'd1,
      RND_UP           = 2'd2,
      RND_DOWN         = 2'd3
   } fpu_rnd_e;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } csr_sel_e;

   // Contiguous run of ones starting at bit lsb
   function automatic logic [63:0] field_mask(input int lsb, input int width);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < width; i++) m[lsb + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/fpu_csr_ctrl.sv
module fpu_csr_ctrl
   import fpu_csr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FLAG_LSB = 7,
   parameter int FLAG_W   = 5,
   parameter bit LEGACY   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_q,
   output fpu_rnd_e          rnd
);
   localparam logic [63:0] FLAG_FIELD = field_mask(FLAG_LSB, FLAG_W);
   localparam logic [63:0] LOW_FIELD  = field_mask(0, FLAG_LSB);

   logic [DATA_W-1:0] keep_mask;

   generate
      if (LEGACY) begin : g_legacy
         assign keep_mask = ~FLAG_FIELD[DATA_W-1:0];
      end else begin : g_normal
         assign keep_mask = LOW_FIELD[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wr_data & keep_mask;
   end

   assign rnd = fpu_rnd_e'(ctrl_q[1:0]);
endmodule

// File: rtl/fpu_csr_status.sv
module fpu_csr_status #(
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stat,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic              op_valid,
   input  logic [FLAG_W-1:0] op_flags,
   output logic [FLAG_W-1:0] flags_q
);
   always_ff @(posedge clk) begin
      if (rst)           flags_q <= '0;
      else if (wr_stat)  flags_q <= wr_flags;
      else if (op_valid) flags_q <= flags_q | op_flags;
   end
endmodule

// File: rtl/fpu_csr_rsvd.sv
module fpu_csr_rsvd #(
   parameter int RSVD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [RSVD_W-1:0] upper,
   output logic              err_q
);
   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= wr_en && (|upper);
   end
endmodule

// File: rtl/fpu_csr_bank.sv
module fpu_csr_bank
   import fpu_csr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FLAG_W   = 5,
   parameter int FLAG_LSB = 7,
   parameter int RSVD_LSB = 12,
   parameter bit LEGACY   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              op_valid,
   input  logic [FLAG_W-1:0] op_flags,
   output logic [1:0]        round_mode,
   output logic              rsvd_err
);
   localparam int RSVD_W = DATA_W - RSVD_LSB;
   localparam int PAD_HI = DATA_W - RSVD_LSB;

   generate
      if (FLAG_LSB + FLAG_W != RSVD_LSB) begin : g_bad_layout
         $fatal(1, "flag field must end where the reserved field starts");
      end
      if (FLAG_LSB < 2) begin : g_bad_lsb
         $fatal(1, "flag field overlaps rounding bits");
      end
      if (DATA_W > 64 || RSVD_W < 1) begin : g_bad_width
         $fatal(1, "unsupported word width");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic [FLAG_W-1:0] flags_q;
   fpu_rnd_e          rnd;
   logic              wr_ctrl, wr_stat;

   assign wr_ctrl = wr_en && (csr_sel_e'(wr_sel) == SEL_CTRL);
   assign wr_stat = wr_en && (csr_sel_e'(wr_sel) == SEL_STAT);

   fpu_csr_ctrl #(
      .DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB), .FLAG_W(FLAG_W), .LEGACY(LEGACY)
   ) u_ctrl (
      .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
      .ctrl_q(ctrl_q), .rnd(rnd)
   );

   fpu_csr_status #(.FLAG_W(FLAG_W)) u_stat (
      .clk(clk), .rst(rst), .wr_stat(wr_stat),
      .wr_flags(wr_data[FLAG_LSB +: FLAG_W]),
      .op_valid(op_valid), .op_flags(op_flags), .flags_q(flags_q)
   );

   fpu_csr_rsvd #(.RSVD_W(RSVD_W)) u_rsvd (
      .clk(clk), .rst(rst), .wr_en(wr_en),
      .upper(wr_data[DATA_W-1:RSVD_LSB]), .err_q(rsvd_err)
   );

   assign round_mode = rnd;

   always_comb begin
      if (csr_sel_e'(rd_sel) == SEL_STAT)
         rd_data = {{PAD_HI{1'b0}}, flags_q, {FLAG_LSB{1'b0}}};
      else
         rd_data = ctrl_q;
   end
endmodule

// File: rtl/fpu_csr_bank_chk.sv
module fpu_csr_bank_chk #(
   parameter int DATA_W   = 32,
   parameter int FLAG_W   = 5,
   parameter int FLAG_LSB = 7,
   parameter int RSVD_LSB = 12,
   parameter bit LEGACY   = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic              op_valid,
   input logic [FLAG_W-1:0] op_flags,
   input logic [1:0]        round_mode,
   input logic              rsvd_err,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [FLAG_W-1:0] flags_q
);
   logic [DATA_W-1:0] c_keep, c_stat_keep;
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         c_stat_keep[i] = (i >= FLAG_LSB) && (i < FLAG_LSB + FLAG_W);
         c_keep[i] = LEGACY ? !c_stat_keep[i] : (i < FLAG_LSB);
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (ctrl_q == '0 && flags_q == '0 && !rsvd_err && round_mode == 2'd0));

   // R2
   round_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_sel) |=> round_mode == $past(wr_data[1:0]));

   // R3 R4
   ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_sel) |=> ctrl_q == ($past(wr_data) & c_keep));

   // R5
   rsvd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (|wr_data[DATA_W-1:RSVD_LSB])) |=> rsvd_err);

   // R5
   rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (|wr_data[DATA_W-1:RSVD_LSB])) |=> !rsvd_err);

   // R6
   stat_read_chk: assert property (@(posedge clk) disable iff (rst)
      rd_sel |-> ((rd_data & ~c_stat_keep) == '0));

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !(wr_en && wr_sel)) |=>
         ((flags_q & ($past(flags_q) | $past(op_flags))) == ($past(flags_q) | $past(op_flags))));

   // R8
   stat_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel) |=> flags_q == $past(wr_data[FLAG_LSB +: FLAG_W]));
endmodule

bind fpu_csr_bank fpu_csr_bank_chk #(
   .DATA_W(DATA_W), .FLAG_W(FLAG_W), .FLAG_LSB(FLAG_LSB),
   .RSVD_LSB(RSVD_LSB), .LEGACY(LEGACY)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .rd_sel(rd_sel), .rd_data(rd_data), .op_valid(op_valid), .op_flags(op_flags),
   .round_mode(round_mode), .rsvd_err(rsvd_err), .ctrl_q(ctrl_q), .flags_q(flags_q)
);

// File: tb/fpu_csr_bank_test.sv
module fpu_csr_bank_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, op_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic [4:0]  op_flags = '0;
   logic [31:0] rd_n, rd_l;
   logic [1:0]  rm_n, rm_l;
   logic        err_n, err_l;

   int checks = 0, failures = 0;
   logic [31:0] m_ctrl, m_leg;
   logic [4:0]  m_flags;
   logic        m_err;

   always #4 clk = ~clk;

   fpu_csr_bank #(.LEGACY(1'b0)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_n), .op_valid(op_valid), .op_flags(op_flags),
      .round_mode(rm_n), .rsvd_err(err_n));

   fpu_csr_bank #(.LEGACY(1'b1)) uut_leg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_l), .op_valid(op_valid), .op_flags(op_flags),
      .round_mode(rm_l), .rsvd_err(err_l));

   function automatic logic [31:0] exp_normal(input logic [31:0] d);
      return d & 32'h0000_007F;
   endfunction
   function automatic logic [31:0] exp_legacy(input logic [31:0] d);
      return d & 32'hFFFF_F07F;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // called at a falling edge; compares every visible output against the model
   task automatic check_all(input string tag);
      rd_sel = 1'b0; #1;
      chk({tag, " ctrl"}, rd_n, m_ctrl);
      chk({tag, " ctrl legacy"}, rd_l, m_leg);
      chk({tag, " R2 round"}, {30'd0, rm_n}, {30'd0, m_ctrl[1:0]});
      chk({tag, " R2 round legacy"}, {30'd0, rm_l}, {30'd0, m_leg[1:0]});
      rd_sel = 1'b1; #1;
      chk({tag, " R6 status"}, rd_n, {20'd0, m_flags, 7'd0});
      chk({tag, " R6 status legacy"}, rd_l, {20'd0, m_flags, 7'd0});
      chk({tag, " R5 err"}, {31'd0, err_n}, {31'd0, m_err});
      chk({tag, " R5 err legacy"}, {31'd0, err_l}, {31'd0, m_err});
   endtask

   task automatic cycle(input string tag, input logic we, input logic sel,
                        input logic [31:0] d, input logic ov, input logic [4:0] fl);
      wr_en = we; wr_sel = sel; wr_data = d; op_valid = ov; op_flags = fl;
      @(posedge clk);
      m_err = we && (|d[31:12]);
      if (we && !sel) begin
         m_ctrl = exp_normal(d);
         m_leg  = exp_legacy(d);
      end
      if (we && sel)  m_flags = d[11:7];
      else if (ov)    m_flags = m_flags | fl;
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      m_ctrl = '0; m_leg = '0; m_flags = '0; m_err = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_all("R1 reset");

      // R2 rounding encodings
      cycle("R2 toward -inf", 1, 0, 32'h3, 0, 0);
      cycle("R2 toward zero", 1, 0, 32'h1, 0, 0);
      cycle("R2 toward +inf", 1, 0, 32'h2, 0, 0);
      // R3 R4 R5 all-ones control write
      cycle("R3 R4 R5 ctrl ones", 1, 0, 32'hFFFF_FFFF, 0, 0);
      cycle("R5 pulse ends", 0, 0, 32'hFFFF_FFFF, 0, 0);
      // R3 flag-field positions dropped in both variants, no pulse
      cycle("R3 R4 ctrl flagfield", 1, 0, 32'h0000_0F80, 0, 0);
      // R6 R5 status all-ones
      cycle("R6 R5 stat ones", 1, 1, 32'hFFFF_FFFF, 0, 0);
      // R8 write beats simultaneous flags
      cycle("R8 write wins", 1, 1, 32'h0, 1, 5'h1F);
      // R7 accumulation: inexact then overflow, then ignored invalid
      cycle("R7 inexact", 0, 0, 32'h0, 1, 5'h01);
      cycle("R7 overflow", 0, 0, 32'h0, 1, 5'h04);
      cycle("R7 no valid", 0, 0, 32'h0, 0, 5'h10);
      cycle("R7 invalid", 0, 1, 32'hFFFF_F000, 1, 5'h10);
      // R6 status write of single divide-by-zero flag
      cycle("R6 divzero", 1, 1, 32'h0000_0400, 0, 0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] d;
         d = $urandom;
         if ($urandom_range(0, 1) == 0) d[31:12] = '0;
         cycle("RAND", ($urandom_range(0, 2) == 0), $urandom_range(0, 1), d,
               $urandom_range(0, 1), 5'($urandom));
      end

      // R1 mid-run reset
      wr_en = 1'b0; op_valid = 1'b0;
      rst = 1'b1;
      @(posedge clk);
      m_ctrl = '0; m_leg = '0; m_flags = '0; m_err = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      check_all("R1 rerun reset");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule